// File: doc/BRIEF.md
# I2C Bus Error and Arbitration Monitor

This block sits next to an I2C controller and watches the two bus lines for two kinds of fault. The first is a START or STOP that lands inside a byte frame instead of on a frame boundary. The second is a lost arbitration, where the node releases SDA high but another device holds it low. The controller tells the monitor whether it is a master or an addressed slave, whether a slave is still taking in its address, what the node is driving on SDA, and which phase of the transfer is running.

The raw SCL and SDA inputs first pass through a synchronizer. The block then finds bus conditions and counts complete SCL pulses since the last START or STOP. From these it raises sticky error flags and an interrupt that an enable can mask. It also gives one-cycle pulses that tell the controller to:
- let go of both lines,
- drop a pending start request,
- fall back to slave mode,
- restart address recognition.

Top module: `i2c_fault_monitor`

## Requirements
- R1: SCL and SDA pass through a two-flop synchronizer. A START is a falling synchronized SDA while synchronized SCL is high in both the current and the previous sample. A STOP is the same with a rising SDA. Flags and pulses appear on the third clock edge after the raw line change.
- R2: A START or STOP raises `bus_err_flag` when the number of complete SCL pulses since the last START or STOP is not a multiple of 9 and the node is involved.
- R3: `bus_err_flag` is never raised by a condition that arrives while the node is neither master nor addressed slave, or while `in_addr_phase` is 1.
- R4: When `is_master` is 0, every START pulses `addr_restart` high for one cycle, whether or not it is aligned to a frame.
- R5: As master, with `phase` at address (2'b01), data (2'b10) or acknowledge (2'b11), an SCL rising edge that sees SDA low while `sda_drive` is 1 sets `arb_lost_flag`. It also pulses `release_lines`, `clr_start_req` and `to_slave` once each.
- R6: As addressed slave (`is_master` 0), arbitration loss is checked only when `phase` is data or acknowledge. On a loss it sets `arb_lost_flag` and pulses `release_lines` only. In the address phase it has no effect.
- R7: Both error flags stay set until `err_clr` is high at a clock edge. A new error that arrives in the same cycle as `err_clr` leaves its flag set.
- R8: The pulse count is cleared by every START and STOP. It advances on each SCL falling edge that follows a rising edge, and it wraps to 0 after 9. This makes 9 or 18 pulses aligned and 10 pulses misaligned.
- R9: `err_irq` is high exactly when `err_ie` is 1 and at least one error flag is set.
- R10: An SCL rise with SDA low while `sda_drive` is 0 does not set `arb_lost_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_drive | input | 1 | 1 when the node releases SDA high |
| is_master | input | 1 | Node is acting as master |
| is_addr_slave | input | 1 | Node is an addressed slave |
| in_addr_phase | input | 1 | Slave is still receiving its address |
| phase | input | 2 | 00 idle, 01 address, 10 data, 11 acknowledge |
| err_ie | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Clear strobe for both error flags |
| bus_err_flag | output | 1 | Sticky misplaced-condition flag |
| arb_lost_flag | output | 1 | Sticky arbitration-loss flag |
| err_irq | output | 1 | Error interrupt |
| release_lines | output | 1 | Pulse: release SCL and SDA |
| clr_start_req | output | 1 | Pulse: drop pending master start request |
| to_slave | output | 1 | Pulse: switch to slave mode |
| addr_restart | output | 1 | Pulse: enter address recognition |

## Verification
The properties assume the role inputs change only between bus events and stay steady across the few cycles from a line change to the registered result. This matters because the past-role checks compare a flag rise against the role seen one edge earlier. The stimulus changes only one line at a time, then waits four clocks before the next change, so each condition or SCL edge is seen alone. Role, phase and drive inputs change only while the lines are idle or SCL is low.

// File: rtl/i2c_fault_monitor.sv
module i2c_fault_monitor #(
  parameter int FRAME_LEN   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       sda_drive,
  input  logic       is_master,
  input  logic       is_addr_slave,
  input  logic       in_addr_phase,
  input  logic [1:0] phase,
  input  logic       err_ie,
  input  logic       err_clr,
  output logic       bus_err_flag,
  output logic       arb_lost_flag,
  output logic       err_irq,
  output logic       release_lines,
  output logic       clr_start_req,
  output logic       to_slave,
  output logic       addr_restart
);
  localparam int CW = $clog2(FRAME_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);
  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_DATA = 2'b10;
  localparam logic [1:0] PH_ACK  = 2'b11;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, armed;
  logic [CW-1:0] bit_cnt;

  wire scl_s = scl_sh[SYNC_STAGES-1];
  wire sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_hi   = scl_s & scl_q;
  wire start_c  = scl_hi & sda_q & ~sda_s;
  wire stop_c   = scl_hi & ~sda_q & sda_s;
  wire cond     = start_c | stop_c;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      armed   <= 1'b0;
    end else if (cond) begin
      bit_cnt <= '0;
      armed   <= 1'b0;
    end else if (scl_rise) begin
      armed   <= 1'b1;
    end else if (scl_fall && armed) begin
      armed   <= 1'b0;
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
    end

  wire involved = is_master | (is_addr_slave & ~in_addr_phase);
  wire bus_evt  = cond & (bit_cnt != '0) & involved;

  wire lost_hi  = scl_rise & sda_drive & ~sda_s;
  wire m_check  = is_master & (phase != PH_IDLE);
  wire s_check  = ~is_master & is_addr_slave & ((phase == PH_DATA) | (phase == PH_ACK));
  wire arb_evt  = lost_hi & (m_check | s_check);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_err_flag  <= 1'b0;
      arb_lost_flag <= 1'b0;
      release_lines <= 1'b0;
      clr_start_req <= 1'b0;
      to_slave      <= 1'b0;
      addr_restart  <= 1'b0;
    end else begin
      bus_err_flag  <= bus_evt | (bus_err_flag & ~err_clr);
      arb_lost_flag <= arb_evt | (arb_lost_flag & ~err_clr);
      release_lines <= arb_evt;
      clr_start_req <= arb_evt & is_master;
      to_slave      <= arb_evt & is_master;
      addr_restart  <= start_c & ~is_master;
    end

  assign err_irq = err_ie & (bus_err_flag | arb_lost_flag);
endmodule

// File: rtl/i2c_fault_monitor_chk.sv
module i2c_fault_monitor_chk #(
  parameter int CW = 4,
  parameter int FRAME_LEN = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_master,
  input logic          is_addr_slave,
  input logic          in_addr_phase,
  input logic          err_ie,
  input logic          err_clr,
  input logic          bus_err_flag,
  input logic          arb_lost_flag,
  input logic          err_irq,
  input logic          release_lines,
  input logic          clr_start_req,
  input logic [CW-1:0] bit_cnt
);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_ie |-> !err_irq);
  // R9
  irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ie && (bus_err_flag || arb_lost_flag)) |-> err_irq);
  // R7
  bus_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_flag && !err_clr) |=> bus_err_flag);
  // R7
  arb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_flag && !err_clr) |=> arb_lost_flag);
  // R3
  bus_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err_flag) |-> $past(is_master || (is_addr_slave && !in_addr_phase)));
  // R5
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost_flag) |-> release_lines);
  // R5
  start_clr_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start_req |-> $past(is_master));
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CW'(FRAME_LEN));
endmodule

bind i2c_fault_monitor i2c_fault_monitor_chk #(.CW(CW), .FRAME_LEN(FRAME_LEN)) u_chk (.*);

// File: tb/i2c_fault_monitor_tb.sv
`timescale 1ns/1ps
module i2c_fault_monitor_tb;
  logic clk = 0, rst_n = 0;
  logic scl = 1, sda = 1, sda_drive = 0;
  logic is_master = 0, is_addr_slave = 0, in_addr_phase = 0, err_ie = 0, err_clr = 0;
  logic [1:0] phase = 2'b00;
  logic bus_err_flag, arb_lost_flag, err_irq, release_lines, clr_start_req, to_slave, addr_restart;
  int checks = 0, errors = 0;
  int n_rel = 0, n_clr = 0, n_slv = 0, n_addr = 0, n_bhi = 0;

  always #10 clk = ~clk;

  i2c_fault_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .sda_drive(sda_drive),
    .is_master(is_master), .is_addr_slave(is_addr_slave), .in_addr_phase(in_addr_phase),
    .phase(phase), .err_ie(err_ie), .err_clr(err_clr),
    .bus_err_flag(bus_err_flag), .arb_lost_flag(arb_lost_flag), .err_irq(err_irq),
    .release_lines(release_lines), .clr_start_req(clr_start_req), .to_slave(to_slave),
    .addr_restart(addr_restart));

  always @(negedge clk) if (rst_n) begin
    n_rel  += int'(release_lines);
    n_clr  += int'(clr_start_req);
    n_slv  += int'(to_slave);
    n_addr += int'(addr_restart);
    n_bhi  += int'(bus_err_flag);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic line(input logic c, input logic d);
    scl = c; sda = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic restart_dut();
    scl = 1; sda = 1; rst_n = 0;
    is_master = 0; is_addr_slave = 0; in_addr_phase = 0; phase = 2'b00;
    sda_drive = 0; err_ie = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    n_rel = 0; n_clr = 0; n_slv = 0; n_addr = 0; n_bhi = 0;
  endtask

  task automatic do_start(); line(1,1); line(1,0); line(0,0); endtask
  task automatic do_stop();  line(0,0); line(1,0); line(1,1); endtask
  task automatic do_rstart(); line(0,1); line(1,1); line(1,0); line(0,0); endtask
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin line(0,1); line(1,1); line(0,1); end
  endtask

  task automatic t_reset();
    restart_dut();
    check("R7 reset bus flag", bus_err_flag, 0);
    check("R7 reset arb flag", arb_lost_flag, 0);
    check("R9 reset irq", err_irq, 0);
  endtask

  task automatic t_aligned();
    restart_dut(); is_master = 1;
    do_start(); pulses(9); do_stop();
    check("R2 aligned 9 pulses", bus_err_flag, 0);
    do_start(); pulses(18); do_stop();
    check("R8 aligned 18 pulses", bus_err_flag, 0);
  endtask

  task automatic t_wrap();
    restart_dut(); is_master = 1;
    do_start(); pulses(10); do_stop();
    check("R8 10 pulses misaligned", bus_err_flag, 1);
  endtask

  task automatic t_misplaced_master();
    restart_dut(); is_master = 1;
    do_start(); pulses(3); do_stop();
    check("R2 misplaced stop", bus_err_flag, 1);
    check("R9 irq masked", err_irq, 0);
    err_ie = 1; #1;
    check("R9 irq enabled", err_irq, 1);
    repeat (5) @(negedge clk);
    check("R7 flag holds", bus_err_flag, 1);
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    check("R7 cleared", bus_err_flag, 0);
    check("R9 irq drops", err_irq, 0);
  endtask

  task automatic t_latency();
    restart_dut(); is_master = 1;
    do_start(); pulses(2);
    line(0,0); scl = 1; @(negedge clk); sda = 1;
    @(negedge clk); @(negedge clk);
    check("R1 not yet after two edges", bus_err_flag, 0);
    @(negedge clk);
    check("R1 set on third edge", bus_err_flag, 1);
  endtask

  task automatic t_slave_addr_phase();
    restart_dut(); is_addr_slave = 1; in_addr_phase = 1;
    do_start(); pulses(4); do_rstart();
    check("R3 no error in address phase", bus_err_flag, 0);
    check("R4 address restart pulses", n_addr, 2);
  endtask

  task automatic t_slave_restart();
    restart_dut(); is_addr_slave = 1; phase = 2'b10;
    do_start(); pulses(4); do_rstart();
    check("R2 slave misplaced restart", bus_err_flag, 1);
    check("R4 restart on misplaced start", n_addr, 2);
  endtask

  task automatic t_idle_role();
    restart_dut();
    do_start(); pulses(5); do_stop();
    check("R3 uninvolved node", bus_err_flag, 0);
    check("R1 start seen as slave", n_addr, 1);
  endtask

  task automatic t_collision();
    restart_dut(); is_master = 1;
    do_start(); pulses(3);
    err_clr = 1;
    do_stop();
    err_clr = 0;
    check("R7 set wins over clear", n_bhi, 1);
    check("R7 then cleared", bus_err_flag, 0);
  endtask

  task automatic t_arb_master();
    restart_dut(); is_master = 1;
    do_start(); phase = 2'b01; sda_drive = 1;
    line(0,0); line(1,0);
    check("R5 arb flag", arb_lost_flag, 1);
    check("R5 release pulse", n_rel, 1);
    check("R5 start clear pulse", n_clr, 1);
    check("R5 to slave pulse", n_slv, 1);
    restart_dut(); is_master = 1;
    do_start(); phase = 2'b11; sda_drive = 1;
    line(0,0); line(1,0);
    check("R5 arb in ack phase", arb_lost_flag, 1);
  endtask

  task automatic t_arb_slave();
    restart_dut(); is_addr_slave = 1; in_addr_phase = 1; phase = 2'b01;
    do_start(); sda_drive = 1;
    line(0,0); line(1,0); line(0,0);
    check("R6 no arb in address phase", arb_lost_flag, 0);
    check("R6 no release in address phase", n_rel, 0);
    in_addr_phase = 0; phase = 2'b10;
    line(1,0);
    check("R6 arb in data phase", arb_lost_flag, 1);
    check("R6 release pulse", n_rel, 1);
    check("R6 no start clear", n_clr, 0);
    check("R6 no role switch", n_slv, 0);
  endtask

  task automatic t_arb_low();
    restart_dut(); is_master = 1;
    do_start(); phase = 2'b10; sda_drive = 0;
    line(0,0); line(1,0); line(0,0);
    check("R10 driving low no arb", arb_lost_flag, 0);
    check("R10 no release", n_rel, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_aligned();
    t_wrap();
    t_misplaced_master();
    t_latency();
    t_slave_addr_phase();
    t_slave_restart();
    t_idle_role();
    t_collision();
    t_arb_master();
    t_arb_slave();
    t_arb_low();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule